// File: doc/BRIEF.md
# Steerable Two-Output Interrupt Controller

This block gathers up to thirty-two level-sensitive interrupt lines into a first-level controller. Each line passes through a synchronizer and becomes one bit of a read-only pending register. A software-written enable mask lets a source through only when its mask bit is 1. A per-source routing bit then sends each enabled source either to the normal interrupt output (`irq_o`) or to the fast interrupt output (`fiq_o`).

A third output, `wake_o`, tells the power logic that the processor should leave idle. A single control bit selects how this output is formed. When the bit is 0, any pending source raises `wake_o` and the mask is ignored. When the bit is 1, only pending sources that are also enabled in the mask raise it.

Software reaches the mask, routing, control and pending registers through a simple read/write register port. Only a fixed subset of source positions is implemented. The other positions, and every reserved bit, read as zero, ignore writes and never drive an output.

Top module: `intc_steer`

## Requirements
- R1: After reset, `irq_o`, `fiq_o` and `wake_o` are 0, and the mask, routing and control registers all read 0.
- R2: `irq_o` is the OR over implemented sources that are pending, enabled and have routing bit 0. `fiq_o` is the same OR over sources with routing bit 1.
- R3: The routing register is at byte offset 0x08. Bits 8 to 14 and 17 to 31 are writable. Bits 0 to 7, 15 and 16 read 0 and ignore writes.
- R4: The mask register is at byte offset 0x04 and has the same writable bit positions as R3. A mask bit of 1 enables its source, so the reset value of 0 blocks every source from `irq_o` and `fiq_o`.
- R5: The pending register is at byte offset 0x00 and is read-only. It shows the synchronized level of each implemented source and reads 0 at unimplemented positions. Writes to it have no effect.
- R6: The control register is at byte offset 0x14. Bit 0 is the wake-mask select and is writable. Bits 31:1 read 0.
- R7: When the wake-mask select is 0, `wake_o` is 1 whenever any implemented source is pending, whatever the mask holds.
- R8: When the wake-mask select is 1, `wake_o` is 1 only when some implemented source is both pending and enabled in the mask.
- R9: A source at an unimplemented position (0 to 7, 15, 16) never raises `irq_o`, `fiq_o` or `wake_o`.
- R10: A change on `src_i` reaches the outputs on the third rising clock edge after it. A register write reaches the outputs on the edge after the write edge.
- R11: A read returns its data on `bus_rdata_o` after the clock edge that samples `bus_rd_i`. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive interrupt sources |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Idle wakeup request |

## Verification
Each result arrives at a fixed point. A source edge appears on the outputs three rising edges after the source changes: two synchronizer flops and then the output flop. A register write shows on the outputs one edge after the write edge. Read data appears one edge after the read strobe is sampled. The bench drives inputs on falling edges and waits exactly that many rising edges before it samples on the next falling edge. It also checks, one edge before a result is due, that the output still holds its old value. A monitor compares read data with a queue of expected words, and it takes each word out only on the falling edge after a read strobe has been clocked.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int DATA_W = 32;

    localparam logic [7:0] OFS_PEND  = 8'h00;
    localparam logic [7:0] OFS_MASK  = 8'h04;
    localparam logic [7:0] OFS_ROUTE = 8'h08;
    localparam logic [7:0] OFS_CTRL  = 8'h14;

    // implemented source positions: 8..14 and 17..31
    localparam logic [DATA_W-1:0] IMPL_DEFAULT = 32'hFFFE_7F00;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PEND,
        SEL_MASK,
        SEL_ROUTE,
        SEL_CTRL
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] route;
        logic              dim;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    typedef struct packed {
        logic irq;
        logic fiq;
        logic wake;
    } outs_t;
endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign stg_d[g] = async_i;
        end else begin : g_next
            assign stg_d[g] = stg_q[g-1];
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q[g] <= '0;
            else         stg_q[g] <= stg_d[g];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [DATA_W-1:0] IMPL_MAP = IMPL_DEFAULT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] pend_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] mask_o,
    output logic [DATA_W-1:0] route_o,
    output logic              dim_o
);
    regs_t    regs_d, regs_q;
    reg_sel_e sel;

    always_comb begin
        if      (addr_i == ADDR_W'(OFS_PEND))  sel = SEL_PEND;
        else if (addr_i == ADDR_W'(OFS_MASK))  sel = SEL_MASK;
        else if (addr_i == ADDR_W'(OFS_ROUTE)) sel = SEL_ROUTE;
        else if (addr_i == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
        else                                   sel = SEL_NONE;
    end

    always_comb begin
        regs_d = regs_q;

        if (wr_i) begin
            case (sel)
                SEL_MASK:  regs_d.mask  = wdata_i & IMPL_MAP;
                SEL_ROUTE: regs_d.route = wdata_i & IMPL_MAP;
                SEL_CTRL:  regs_d.dim   = wdata_i[0];
                default:   ;
            endcase
        end

        regs_d.rdata = '0;
        if (rd_i) begin
            case (sel)
                SEL_PEND:  regs_d.rdata = pend_i & IMPL_MAP;
                SEL_MASK:  regs_d.rdata = regs_q.mask;
                SEL_ROUTE: regs_d.rdata = regs_q.route;
                SEL_CTRL:  regs_d.rdata = DATA_W'(regs_q.dim);
                default:   regs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign rdata_o = regs_q.rdata;
    assign mask_o  = regs_q.mask;
    assign route_o = regs_q.route;
    assign dim_o   = regs_q.dim;
endmodule

// File: rtl/intc_route.sv
module intc_route
    import intc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] pend_i,
    input  logic [DATA_W-1:0] mask_i,
    input  logic [DATA_W-1:0] route_i,
    input  logic              dim_i,
    output logic              irq_o,
    output logic              fiq_o,
    output logic              wake_o
);
    outs_t             outs_d, outs_q;
    logic [DATA_W-1:0] live;

    always_comb begin
        live        = pend_i & mask_i;
        outs_d.irq  = |(live & ~route_i);
        outs_d.fiq  = |(live & route_i);
        outs_d.wake = dim_i ? (|live) : (|pend_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) outs_q <= '0;
        else         outs_q <= outs_d;
    end

    assign irq_o  = outs_q.irq;
    assign fiq_o  = outs_q.fiq;
    assign wake_o = outs_q.wake;
endmodule

// File: rtl/intc_steer.sv
module intc_steer
    import intc_pkg::*;
#(
    parameter int                NUM_SRC     = 32,
    parameter int                ADDR_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] IMPL_MAP    = IMPL_DEFAULT
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic               irq_o,
    output logic               fiq_o,
    output logic               wake_o
);
    logic [NUM_SRC-1:0] src_sync;
    logic [DATA_W-1:0]  pend_w;
    logic [DATA_W-1:0]  mask_w;
    logic [DATA_W-1:0]  route_w;
    logic               dim_w;

    intc_sync #(
        .WIDTH  (NUM_SRC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (src_i),
        .sync_o  (src_sync)
    );

    assign pend_w = DATA_W'(src_sync) & IMPL_MAP;

    intc_regs #(
        .ADDR_W   (ADDR_W),
        .IMPL_MAP (IMPL_MAP)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .pend_i  (pend_w),
        .rdata_o (bus_rdata_o),
        .mask_o  (mask_w),
        .route_o (route_w),
        .dim_o   (dim_w)
    );

    intc_route u_route (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pend_i  (pend_w),
        .mask_i  (mask_w),
        .route_i (route_w),
        .dim_i   (dim_w),
        .irq_o   (irq_o),
        .fiq_o   (fiq_o),
        .wake_o  (wake_o)
    );
endmodule

// File: rtl/intc_steer_chk.sv
module intc_steer_chk
    import intc_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DATA_W-1:0] pend_i,
    input logic [DATA_W-1:0] mask_i,
    input logic [DATA_W-1:0] route_i,
    input logic              dim_i,
    input logic              irq_i,
    input logic              fiq_i,
    input logic              wake_i
);
    assert_irq_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> ($past(pend_i & mask_i & ~route_i) != '0));

    assert_fiq_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fiq_i |-> ($past(pend_i & mask_i & route_i) != '0));

    assert_mask_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i == '0) |=> (!irq_i && !fiq_i));

    assert_wake_any_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!dim_i && pend_i != '0) |=> wake_i);

    assert_wake_masked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dim_i && (pend_i & mask_i) == '0) |=> !wake_i);

    assert_wake_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |-> ($past(pend_i) != '0));
endmodule

bind intc_steer intc_steer_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pend_i  (pend_w),
    .mask_i  (mask_w),
    .route_i (route_w),
    .dim_i   (dim_w),
    .irq_i   (irq_o),
    .fiq_i   (fiq_o),
    .wake_i  (wake_o)
);

// File: tb/intc_steer_tb.sv
`timescale 1ns/1ps
module intc_steer_tb;
    localparam logic [31:0] MAP = 32'hFFFE_7F00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, fiq, wake;

    int errors = 0;
    int checks = 0;

    logic [31:0] sh_src = '0, sh_mask = '0, sh_route = '0;
    logic        sh_dim = 1'b0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    always #2 clk = ~clk;

    intc_steer u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .src_i       (src),
        .bus_wr_i    (wr),
        .bus_rd_i    (rd),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq),
        .fiq_o       (fiq),
        .wake_o      (wake)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected word per clocked read strobe
    always @(posedge clk) rd_seen <= rd;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("R11", "unexpected read", rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, "read data", rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        if (a == 8'h04) sh_mask  = d & MAP;
        if (a == 8'h08) sh_route = d & MAP;
        if (a == 8'h14) sh_dim   = d[0];
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        rd = 1'b1; addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic chk_out(input string tag);
        logic [31:0] live;
        live = sh_src & MAP & sh_mask;
        check(tag, "irq", {31'b0, irq}, {31'b0, |(live & ~sh_route)});
        check(tag, "fiq", {31'b0, fiq}, {31'b0, |(live & sh_route)});
        check(tag, "wake", {31'b0, wake},
              {31'b0, sh_dim ? (|live) : (|(sh_src & MAP))});
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src = v; sh_src = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_out("R1");
        bus_read(8'h04, 32'h0, "R1");
        bus_read(8'h08, 32'h0, "R1");
        bus_read(8'h14, 32'h0, "R1");

        // R3: reserved routing bits
        bus_write(8'h08, 32'hFFFF_FFFF);
        bus_read(8'h08, 32'hFFFE_7F00, "R3");
        bus_write(8'h08, 32'h0);

        // R6: control register width
        bus_write(8'h14, 32'hFFFF_FFFF);
        bus_read(8'h14, 32'h0000_0001, "R6");
        bus_write(8'h14, 32'h0);

        // R11: unmapped offsets
        bus_read(8'h0C, 32'h0, "R11");
        bus_read(8'h18, 32'h0, "R11");

        // R5: pending ignores writes
        bus_write(8'h00, 32'hFFFF_FFFF);
        bus_read(8'h00, 32'h0, "R5");

        // R10 / R7 / R4: source latency, wake ignores mask
        @(negedge clk);
        src = 32'h0000_0200; sh_src = 32'h0000_0200;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10", "wake before due edge", {31'b0, wake}, 32'h0);
        @(negedge clk);
        chk_out("R7");
        check("R4", "irq blocked by mask", {31'b0, irq}, 32'h0);

        // R10 / R2: register write latency, irq steering
        bus_write(8'h04, 32'h0000_0200);
        check("R10", "irq before due edge", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk_out("R2");

        // R2: route to fast output
        bus_write(8'h08, 32'h0000_0200);
        @(negedge clk);
        chk_out("R2");

        // R8: wake honours mask
        bus_write(8'h14, 32'h1);
        bus_write(8'h04, 32'h0);
        @(negedge clk);
        chk_out("R8");
        check("R8", "wake masked off", {31'b0, wake}, 32'h0);
        bus_write(8'h04, 32'h0000_0200);
        @(negedge clk);
        chk_out("R8");
        check("R8", "wake enabled", {31'b0, wake}, 32'h1);

        // R9: unimplemented positions stay silent
        bus_write(8'h14, 32'h0);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h08, 32'h0);
        set_src(32'h0001_80FF);
        chk_out("R9");
        check("R9", "wake silent", {31'b0, wake}, 32'h0);
        bus_read(8'h00, 32'h0, "R5");
        bus_read(8'h04, 32'hFFFE_7F00, "R4");

        // R2 / R5: both outputs at once
        set_src(32'h0002_0100);
        bus_write(8'h08, 32'h0002_0000);
        @(negedge clk);
        chk_out("R2");
        check("R2", "irq and fiq together", {30'b0, irq, fiq}, 32'h3);
        bus_read(8'h00, 32'h0002_0100, "R5");

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule